// File: doc/BRIEF.md
# Instruction Operand Source Decoder

This block turns the 9-bit source operand field of an instruction into a routing decision for the operand fetch stage. It reports where the value comes from: a general scalar register, a special machine register, a vector register, a built-in constant, the 32-bit literal dword that trails the instruction, or the local-memory direct path. It also reports which register index to read and, for constants and literals, the full 64-bit value that the datapath should consume. An illegal flag marks reserved codes, vector registers named by a non-vector instruction, and scalar register groups that start on a badly aligned index.

The value expansion depends on three side inputs. The first is the operand width (32 or 64 bits). The second is the float type of the operand (none, half, single, double). The third is whether the instruction is scalar or vector. A literal is placed differently for 64-bit scalar and 64-bit vector operands. Float constants come out in the encoding that the operand expects. The decode is combinational. A parameter adds one output register stage so the block fits into a pipelined front end.

Top module: `opsrc_decoder`

## Requirements
- R1: Codes 0 to 103 give kind 0 (general scalar register), and the index equals the code.
- R2: Codes 104 to 127 and codes 251, 252 and 253 give kind 1 (special register), with the index equal to the code. This covers carry halves 106/107, trap temporaries 112 to 123, memory register 124, exec halves 126/127, and the carry-zero, exec-zero and scalar-condition bits at 251/252/253.
- R3: Code 125 and codes 209 to 239, 249 and 250 are reserved and set illegal with an immediate of zero. Code 125 reports kind 1. The others report kind 3.
- R4: Codes 256 to 511 give kind 2 (vector register) with index = code − 256. These codes set illegal when the vector-instruction input is 0.
- R5: The group span input encodes the register count: 0 means 1 register, 1 means 2, 2 means 4 and 3 means 8. For codes 0 to 127, a span of 1 needs an even code, and a span of 2 or 3 needs a code that is a multiple of 4. A code that breaks this sets illegal.
- R6: Codes 128 to 208 give kind 3 with value 0, 1 to 64 (codes 129 to 192) or −1 to −16 (codes 193 to 208). With the 64-bit input at 1, the value is sign-extended over 64 bits. With the 64-bit input at 0, it is a 32-bit two's complement value in bits 31:0 and bits 63:32 are zero.
- R7: Codes 240 to 248 give kind 3 with the values 0.5, −0.5, 1.0, −1.0, 2.0, −2.0, 4.0, −4.0 and 1/(2π), in code order. For a 32-bit operand whose float type is not half (float type encoding: 0 none, 1 half, 2 single, 3 double), the value is an IEEE single in bits 31:0. 1/(2π) is 0x3E22F983.
- R8: For a 64-bit operand whose float type is not half, these float constants are IEEE doubles. 1/(2π) is 0x3FC45F306DC9C882.
- R9: For float type half, these float constants are IEEE half values in bits 15:0 with bits 63:16 zero, whatever the width. 1/(2π) is 0x3118.
- R10: Code 255 gives kind 4 (literal). For a 32-bit operand the value is the literal in bits 31:0 with bits 63:32 zero.
- R11: For a 64-bit operand, a scalar instruction sign-extends the literal to 64 bits. A vector instruction places the literal in bits 63:32 and zero in bits 31:0.
- R12: Code 254 gives kind 5 (local-memory direct). For every code the index equals code bits 7:0. Kinds 0, 1, 2 and 5 report an immediate of zero.
- R13: With the output stage on (the default), results appear one clock after the inputs. A synchronous active-high reset clears kind, index, immediate and illegal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| src_code | input | 9 | Source operand code |
| op_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| vec_instr | input | 1 | 1 = vector instruction, 0 = scalar instruction |
| float_type | input | 2 | 0 none, 1 half, 2 single, 3 double |
| grp_span | input | 2 | Register group size: 0 = 1, 1 = 2, 2 = 4, 3 = 8 registers |
| lit_dword | input | 32 | Literal dword that follows the instruction |
| src_kind | output | 3 | 0 scalar, 1 special, 2 vector, 3 constant, 4 literal, 5 local-memory direct |
| reg_index | output | 8 | Register index (code bits 7:0) |
| imm_value | output | 64 | Resolved constant or literal value |
| illegal | output | 1 | Reserved code, misaligned group or vector register without vector instruction |

## Verification
With the output stage on, every result (kind, index, immediate and illegal) is due exactly one rising edge after the inputs change. No output has a longer path. The bench changes inputs on a falling edge and compares on the following falling edge. That is half a period after the capturing edge, so every compare sees the single registered update and nothing else. One extra probe reads the outputs just before the capturing edge to show they still hold the earlier result. This confirms the one-cycle latency instead of only assuming it.

// File: rtl/opsrc_pkg.sv
package opsrc_pkg;

    localparam int CODE_W = 9;
    localparam int IDX_W  = 8;
    localparam int LIT_W  = 32;
    localparam int VAL_W  = 2 * LIT_W;

    typedef enum logic [2:0] {
        SRC_SGPR    = 3'd0,
        SRC_SPECIAL = 3'd1,
        SRC_VGPR    = 3'd2,
        SRC_ICONST  = 3'd3,
        SRC_LITERAL = 3'd4,
        SRC_LDS     = 3'd5
    } src_kind_e;

    typedef enum logic [1:0] {
        FT_NONE   = 2'd0,
        FT_HALF   = 2'd1,
        FT_SINGLE = 2'd2,
        FT_DOUBLE = 2'd3
    } ftype_e;

    typedef enum logic [1:0] {
        SPAN_1 = 2'd0,
        SPAN_2 = 2'd1,
        SPAN_4 = 2'd2,
        SPAN_8 = 2'd3
    } span_e;

    typedef struct packed {
        src_kind_e          kind;
        logic [IDX_W-1:0]   index;
        logic               illegal;
    } route_t;

    typedef struct packed {
        route_t             route;
        logic [VAL_W-1:0]   imm;
    } opsrc_out_t;

    // code space landmarks
    localparam logic [CODE_W-1:0] C_SCALAR_TOP  = 9'd127;
    localparam logic [CODE_W-1:0] C_RSVD_LOW    = 9'd125;
    localparam logic [CODE_W-1:0] C_ZERO        = 9'd128;
    localparam logic [CODE_W-1:0] C_POS_LAST    = 9'd192;
    localparam logic [CODE_W-1:0] C_NEG_LAST    = 9'd208;
    localparam logic [CODE_W-1:0] C_RSVD_HI_END = 9'd239;
    localparam logic [CODE_W-1:0] C_FLT_FIRST   = 9'd240;
    localparam logic [CODE_W-1:0] C_FLT_LAST    = 9'd248;
    localparam logic [CODE_W-1:0] C_RSVD_A      = 9'd249;
    localparam logic [CODE_W-1:0] C_RSVD_B      = 9'd250;
    localparam logic [CODE_W-1:0] C_LDS         = 9'd254;
    localparam logic [CODE_W-1:0] C_LIT         = 9'd255;

    function automatic logic [15:0] flt_half(input logic [3:0] sel);
        case (sel)
            4'd0:    flt_half = 16'h3800;
            4'd1:    flt_half = 16'hB800;
            4'd2:    flt_half = 16'h3C00;
            4'd3:    flt_half = 16'hBC00;
            4'd4:    flt_half = 16'h4000;
            4'd5:    flt_half = 16'hC000;
            4'd6:    flt_half = 16'h4400;
            4'd7:    flt_half = 16'hC400;
            4'd8:    flt_half = 16'h3118;
            default: flt_half = 16'h0000;
        endcase
    endfunction

    function automatic logic [31:0] flt_single(input logic [3:0] sel);
        case (sel)
            4'd0:    flt_single = 32'h3F00_0000;
            4'd1:    flt_single = 32'hBF00_0000;
            4'd2:    flt_single = 32'h3F80_0000;
            4'd3:    flt_single = 32'hBF80_0000;
            4'd4:    flt_single = 32'h4000_0000;
            4'd5:    flt_single = 32'hC000_0000;
            4'd6:    flt_single = 32'h4080_0000;
            4'd7:    flt_single = 32'hC080_0000;
            4'd8:    flt_single = 32'h3E22_F983;
            default: flt_single = 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [63:0] flt_double(input logic [3:0] sel);
        case (sel)
            4'd0:    flt_double = 64'h3FE0_0000_0000_0000;
            4'd1:    flt_double = 64'hBFE0_0000_0000_0000;
            4'd2:    flt_double = 64'h3FF0_0000_0000_0000;
            4'd3:    flt_double = 64'hBFF0_0000_0000_0000;
            4'd4:    flt_double = 64'h4000_0000_0000_0000;
            4'd5:    flt_double = 64'hC000_0000_0000_0000;
            4'd6:    flt_double = 64'h4010_0000_0000_0000;
            4'd7:    flt_double = 64'hC010_0000_0000_0000;
            4'd8:    flt_double = 64'h3FC4_5F30_6DC9_C882;
            default: flt_double = 64'h0;
        endcase
    endfunction

endpackage

// File: rtl/opsrc_classify.sv
module opsrc_classify
    import opsrc_pkg::*;
#(
    parameter int SGPR_LAST = 103
) (
    input  logic [CODE_W-1:0] code,
    input  logic              vec_instr,
    input  span_e             span,
    output route_t            route
);
    localparam logic [CODE_W-1:0] SGPR_TOP = CODE_W'(SGPR_LAST);

    logic misaligned;

    // alignment only matters inside the scalar register space
    always_comb begin
        misaligned = 1'b0;
        if (code <= C_SCALAR_TOP) begin
            case (span)
                SPAN_1:         misaligned = 1'b0;
                SPAN_2:         misaligned = code[0];
                SPAN_4, SPAN_8: misaligned = |code[1:0];
                default:        misaligned = 1'b0;
            endcase
        end
    end

    always_comb begin
        route.index   = code[IDX_W-1:0];
        route.kind    = SRC_ICONST;
        route.illegal = 1'b0;
        if (code[CODE_W-1]) begin
            route.kind    = SRC_VGPR;
            route.illegal = ~vec_instr;
        end else if (code <= SGPR_TOP) begin
            route.kind    = SRC_SGPR;
            route.illegal = misaligned;
        end else if (code <= C_SCALAR_TOP) begin
            route.kind    = SRC_SPECIAL;
            route.illegal = misaligned | (code == C_RSVD_LOW);
        end else if (code <= C_NEG_LAST) begin
            route.kind    = SRC_ICONST;
        end else if (code <= C_RSVD_HI_END) begin
            route.kind    = SRC_ICONST;
            route.illegal = 1'b1;
        end else if (code <= C_FLT_LAST) begin
            route.kind    = SRC_ICONST;
        end else if (code == C_RSVD_A || code == C_RSVD_B) begin
            route.kind    = SRC_ICONST;
            route.illegal = 1'b1;
        end else if (code == C_LDS) begin
            route.kind    = SRC_LDS;
        end else if (code == C_LIT) begin
            route.kind    = SRC_LITERAL;
        end else begin
            route.kind    = SRC_SPECIAL;
        end
    end
endmodule

// File: rtl/opsrc_immgen.sv
module opsrc_immgen
    import opsrc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              op_wide,
    input  logic              vec_instr,
    input  ftype_e            ftype,
    input  logic [LIT_W-1:0]  lit,
    output logic [VAL_W-1:0]  imm
);
    logic [VAL_W-1:0] int_val;
    logic [VAL_W-1:0] flt_val;
    logic [VAL_W-1:0] lit_val;
    logic [7:0]       mag;

    // integer constants: exact, sign-extended to operand width
    always_comb begin
        mag = 8'd0;
        int_val = '0;
        if (code <= C_POS_LAST) begin
            mag     = code[7:0] - 8'd128;
            int_val = {{(VAL_W-8){1'b0}}, mag};
        end else begin
            mag     = code[7:0] - 8'd192;
            int_val = VAL_W'(0) - {{(VAL_W-8){1'b0}}, mag};
        end
        if (!op_wide) begin
            int_val[VAL_W-1:LIT_W] = '0;
        end
    end

    // float constants in the operand's encoding
    always_comb begin
        if (ftype == FT_HALF) begin
            flt_val = {{(VAL_W-16){1'b0}}, flt_half(code[3:0])};
        end else if (op_wide) begin
            flt_val = flt_double(code[3:0]);
        end else begin
            flt_val = {{(VAL_W-LIT_W){1'b0}}, flt_single(code[3:0])};
        end
    end

    // literal placement
    always_comb begin
        if (!op_wide) begin
            lit_val = {{(VAL_W-LIT_W){1'b0}}, lit};
        end else if (vec_instr) begin
            lit_val = {lit, {LIT_W{1'b0}}};
        end else begin
            lit_val = {{(VAL_W-LIT_W){lit[LIT_W-1]}}, lit};
        end
    end

    always_comb begin
        if (code[CODE_W-1]) begin
            imm = '0;
        end else if (code >= C_ZERO && code <= C_NEG_LAST) begin
            imm = int_val;
        end else if (code >= C_FLT_FIRST && code <= C_FLT_LAST) begin
            imm = flt_val;
        end else if (code == C_LIT) begin
            imm = lit_val;
        end else begin
            imm = '0;
        end
    end
endmodule

// File: rtl/opsrc_decoder.sv
module opsrc_decoder
    import opsrc_pkg::*;
#(
    parameter int SGPR_LAST = 103,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [8:0]  src_code,
    input  logic        op_wide,
    input  logic        vec_instr,
    input  logic [1:0]  float_type,
    input  logic [1:0]  grp_span,
    input  logic [31:0] lit_dword,
    output logic [2:0]  src_kind,
    output logic [7:0]  reg_index,
    output logic [63:0] imm_value,
    output logic        illegal
);
    route_t           route_c;
    logic [VAL_W-1:0] imm_c;
    opsrc_out_t       res_c;
    opsrc_out_t       res_q;

    opsrc_classify #(.SGPR_LAST(SGPR_LAST)) u_classify (
        .code      (src_code),
        .vec_instr (vec_instr),
        .span      (span_e'(grp_span)),
        .route     (route_c)
    );

    opsrc_immgen u_immgen (
        .code      (src_code),
        .op_wide   (op_wide),
        .vec_instr (vec_instr),
        .ftype     (ftype_e'(float_type)),
        .lit       (lit_dword),
        .imm       (imm_c)
    );

    assign res_c.route = route_c;
    assign res_c.imm   = imm_c;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_c;
                end
            end
        end else begin : g_comb
            assign res_q = res_c;
        end
    endgenerate

    assign src_kind  = res_q.route.kind;
    assign reg_index = res_q.route.index;
    assign illegal   = res_q.route.illegal;
    assign imm_value = res_q.imm;
endmodule

// File: rtl/opsrc_decoder_chk.sv
module opsrc_decoder_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [8:0]  src_code,
    input logic        op_wide,
    input logic        vec_instr,
    input logic [1:0]  float_type,
    input logic [1:0]  grp_span,
    input logic [31:0] lit_dword,
    input logic [2:0]  src_kind,
    input logic [7:0]  reg_index,
    input logic [63:0] imm_value,
    input logic        illegal
);
    logic [8:0]  d_code;
    logic        d_wide;
    logic        d_vec;
    logic [1:0]  d_ft;
    logic [1:0]  d_span;
    logic [31:0] d_lit;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_code <= '0;
                    d_wide <= 1'b0;
                    d_vec  <= 1'b0;
                    d_ft   <= '0;
                    d_span <= '0;
                    d_lit  <= '0;
                end else begin
                    d_code <= src_code;
                    d_wide <= op_wide;
                    d_vec  <= vec_instr;
                    d_ft   <= float_type;
                    d_span <= grp_span;
                    d_lit  <= lit_dword;
                end
            end
        end else begin : g_nodly
            assign d_code = src_code;
            assign d_wide = op_wide;
            assign d_vec  = vec_instr;
            assign d_ft   = float_type;
            assign d_span = grp_span;
            assign d_lit  = lit_dword;
        end
    endgenerate

    p_reserved_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (d_code == 9'd125 || (d_code >= 9'd209 && d_code <= 9'd239) ||
         d_code == 9'd249 || d_code == 9'd250) |-> (illegal && imm_value == 64'h0));

    p_vgpr_route_r4: assert property (@(posedge clk) disable iff (rst)
        d_code[8] |-> (src_kind == 3'd2 && reg_index == d_code[7:0] && illegal == !d_vec));

    p_group_align_r5: assert property (@(posedge clk) disable iff (rst)
        (d_code < 9'd128 && d_span != 2'd0 && d_code[1:0] != 2'd0 &&
         !(d_span == 2'd1 && !d_code[0])) |-> illegal);

    p_int_narrow_r6: assert property (@(posedge clk) disable iff (rst)
        (d_code >= 9'd128 && d_code <= 9'd208 && !d_wide) |-> (imm_value[63:32] == 32'h0));

    p_half_upper_r9: assert property (@(posedge clk) disable iff (rst)
        (d_code >= 9'd240 && d_code <= 9'd248 && d_ft == 2'd1) |-> (imm_value[63:16] == 48'h0));

    p_lit_vector_wide_r11: assert property (@(posedge clk) disable iff (rst)
        (d_code == 9'd255 && d_wide && d_vec) |-> (imm_value == {d_lit, 32'h0}));

    p_lds_route_r12: assert property (@(posedge clk) disable iff (rst)
        (d_code == 9'd254) |-> (src_kind == 3'd5 && imm_value == 64'h0));
endmodule

bind opsrc_decoder opsrc_decoder_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_code   (src_code),
    .op_wide    (op_wide),
    .vec_instr  (vec_instr),
    .float_type (float_type),
    .grp_span   (grp_span),
    .lit_dword  (lit_dword),
    .src_kind   (src_kind),
    .reg_index  (reg_index),
    .imm_value  (imm_value),
    .illegal    (illegal)
);

// File: tb/opsrc_decoder_bench.sv
`timescale 1ns/1ps
module opsrc_decoder_bench;
    localparam real HALF_PERIOD = 10.0;

    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  src_code;
    logic        op_wide;
    logic        vec_instr;
    logic [1:0]  float_type;
    logic [1:0]  grp_span;
    logic [31:0] lit_dword;
    logic [2:0]  src_kind;
    logic [7:0]  reg_index;
    logic [63:0] imm_value;
    logic        illegal;

    int compared = 0;
    int mismatched = 0;

    always #(HALF_PERIOD) clk = ~clk;

    opsrc_decoder u_opsrc_decoder (
        .clk        (clk),
        .rst        (rst),
        .src_code   (src_code),
        .op_wide    (op_wide),
        .vec_instr  (vec_instr),
        .float_type (float_type),
        .grp_span   (grp_span),
        .lit_dword  (lit_dword),
        .src_kind   (src_kind),
        .reg_index  (reg_index),
        .imm_value  (imm_value),
        .illegal    (illegal)
    );

    function automatic string req_of(int c);
        if (c >= 256)                       return "R4";
        if (c <= 103)                       return "R1/R5";
        if (c == 125)                       return "R3";
        if (c <= 127)                       return "R2/R5";
        if (c <= 208)                       return "R6";
        if (c <= 239 || c == 249 || c == 250) return "R3";
        if (c <= 248)                       return "R7/R8/R9";
        if (c <= 253)                       return "R2";
        if (c == 254)                       return "R12";
        return "R10/R11";
    endfunction

    function automatic logic [2:0] exp_kind(int c);
        if (c >= 256) return 3'd2;
        if (c <= 103) return 3'd0;
        if (c <= 127) return 3'd1;
        if (c <= 250) return 3'd3;
        if (c <= 253) return 3'd1;
        if (c == 254) return 3'd5;
        return 3'd4;
    endfunction

    function automatic logic exp_illegal(int c, bit vec, int span);
        bit bad = 0;
        if (c == 125 || (c >= 209 && c <= 239) || c == 249 || c == 250) bad = 1;
        if (c >= 256 && !vec) bad = 1;
        if (c < 128) begin
            if (span == 1 && (c % 2) != 0) bad = 1;
            if (span >= 2 && (c % 4) != 0) bad = 1;
        end
        return bad;
    endfunction

    function automatic logic [63:0] exp_float(int i, bit wide, int ft);
        int e = i / 2 - 1;
        bit neg = (i % 2) == 1;
        logic [63:0] v;
        if (ft == 1) begin
            if (i == 8) return 64'h3118;
            v = '0;
            v[15] = neg;
            v[14:10] = 5'(15 + e);
            return v;
        end
        if (wide) begin
            if (i == 8) return 64'h3FC4_5F30_6DC9_C882;
            v = '0;
            v[63] = neg;
            v[62:52] = 11'(1023 + e);
            return v;
        end
        if (i == 8) return 64'h3E22_F983;
        v = '0;
        v[31] = neg;
        v[30:23] = 8'(127 + e);
        return v;
    endfunction

    function automatic logic [63:0] exp_imm(int c, bit wide, bit vec, int ft, logic [31:0] lit);
        longint n;
        logic [63:0] v;
        if (c >= 128 && c <= 208) begin
            if (c <= 192) n = c - 128;
            else          n = -(c - 192);
            v = 64'(n);
            if (!wide) v[63:32] = '0;
            return v;
        end
        if (c >= 240 && c <= 248) return exp_float(c - 240, wide, ft);
        if (c == 255) begin
            if (!wide) return {32'h0, lit};
            if (vec)   return {lit, 32'h0};
            return {{32{lit[31]}}, lit};
        end
        return 64'h0;
    endfunction

    task automatic check_out(string req, logic [2:0] k, logic [7:0] ix, logic [63:0] im, logic il);
        compared++;
        if (src_kind !== k || reg_index !== ix || imm_value !== im || illegal !== il) begin
            mismatched++;
            $display("FAIL %s: got kind=%0d idx=%0d imm=%h ill=%b, expected kind=%0d idx=%0d imm=%h ill=%b",
                     req, src_kind, reg_index, imm_value, illegal, k, ix, im, il);
        end
    endtask

    initial begin
        #(4_000_000);
        mismatched++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        src_code   = 9'd255;
        op_wide    = 1'b1;
        vec_instr  = 1'b1;
        float_type = 2'd2;
        grp_span   = 2'd3;
        lit_dword  = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        // R13: reset state
        check_out("R13 reset", 3'd0, 8'd0, 64'h0, 1'b0);
        rst = 1'b0;

        // R13: latency probe, outputs hold until the capturing edge
        @(negedge clk);
        src_code = 9'd300; vec_instr = 1'b0; grp_span = 2'd0;
        @(negedge clk);
        check_out("R13 first", 3'd2, 8'd44, 64'h0, 1'b1);
        src_code = 9'd130; op_wide = 1'b0;
        #(HALF_PERIOD - 2.0);
        check_out("R13 hold", 3'd2, 8'd44, 64'h0, 1'b1);
        @(negedge clk);
        check_out("R13 update", 3'd3, 8'd130, 64'd2, 1'b0);

        // exhaustive sweep: all codes, widths, instruction kinds, float types, spans
        for (int c = 0; c < 512; c++) begin
            for (int cfg = 0; cfg < 64; cfg++) begin
                logic [31:0] lit;
                bit w, v;
                int ft, sp;
                w  = cfg[0];
                v  = cfg[1];
                ft = (cfg >> 2) & 3;
                sp = (cfg >> 4) & 3;
                lit = cfg[2] ? (32'h8765_4321 ^ 32'(c)) : (32'h1357_9BDF ^ 32'(cfg));
                src_code   = 9'(c);
                op_wide    = w;
                vec_instr  = v;
                float_type = 2'(ft);
                grp_span   = 2'(sp);
                lit_dword  = lit;
                @(negedge clk);
                check_out(req_of(c), exp_kind(c), 8'(c % 256),
                          exp_imm(c, w, v, ft, lit), exp_illegal(c, v, sp));
            end
        end

        // R13: synchronous reset clears a live result
        src_code = 9'd255; op_wide = 1'b0; lit_dword = 32'hCAFE_F00D;
        @(negedge clk);
        check_out("R10 pre-reset", 3'd4, 8'd255, 64'h0000_0000_CAFE_F00D, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check_out("R13 reset clear", 3'd0, 8'd0, 64'h0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule